// File: doc/BRIEF.md
# String-Short Fault Latch

This block records protection events for a four-string LED current-sink driver. Each string has a fast comparator whose trip output is already a digital level. There is also one overvoltage trip. Every trip is passed through a two-stage synchroniser. A trip then sets a sticky bit in an 8-bit fault status word, which a host reads at register address 0x0A. A string-short bit also turns off that string's enable line. It also raises a freeze flag that tells the measurement controller to stop converting on that channel.

A latched event cannot be cleared by the trip input going low again. The only ways to clear the bits are the synchronous reset, which stands for a power cycle, or the global driver enable going low. While the enable is low, all latched bits are held at zero, no string is enabled and new trips are not recorded. When the enable returns high, the block starts again from a clean state.

Top module: `led_short_fault_reg`

## Requirements
- R1: On the first clock edge with `rst_n` low, `fault_word` becomes 0x00 and `meas_freeze` becomes 0. From then on `str_en` equals `{4{drv_en}}` until a fault is latched.
- R2: Suppose `short_trip[n]` is high at a rising clock edge N, `drv_en` is high and `rst_n` is high at edges N through N+2. Then `fault_word[n]` (string n at bit n, bits 3:0) is 1 after edge N+2.
- R3: Once set, a string-short bit stays at 1 after its trip input returns low. It stays set for as long as `drv_en` and `rst_n` remain high.
- R4: `str_en[n]` is combinationally equal to `drv_en & ~fault_word[n]`.
- R5: The overvoltage trip `ov_trip` is recorded in `fault_word[4]`. It has the same latency as R2 and is sticky in the same way as R3.
- R6: `fault_word[7:5]` always reads as zero.
- R7: A rising edge sampled with `drv_en` low clears `fault_word[4:0]`. Trips seen while `drv_en` is low are not recorded.
- R8: `meas_freeze[n]` equals the latched short bit `fault_word[n]` at all times.
- R9: A trip held high across a single rising edge is enough to latch its bit.
- R10: A trip on one string leaves the fault bits, enables and freeze flags of the other strings unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset (power cycle) |
| drv_en | input | 1 | Global driver enable; low clears and blocks faults |
| short_trip | input | 4 | Per-string short comparator trips, asynchronous |
| ov_trip | input | 1 | Overvoltage comparator trip, asynchronous |
| fault_word | output | 8 | Fault status word (address 0x0A): [3:0] shorts, [4] overvoltage, [7:5] zero |
| str_en | output | 4 | Per-string enable to the current sinks |
| meas_freeze | output | 4 | Per-channel stop flag to the conversion controller |

## Verification
A trip sampled at edge N shows up in `fault_word` and `meas_freeze` after edge N+2. A clear caused by a low `drv_en` shows up after the very next edge. `str_en` follows `drv_en` within the same cycle. The bench models the two-edge delay with a queue of earlier trip samples that it updates at each rising edge. It drives inputs a quarter period after the edge and compares every output at the falling edge. At that point each output has settled to the value due for that cycle.

// File: rtl/led_fault_pkg.sv
// Package: shared widths and field positions of the fault status word.
package led_fault_pkg;
    localparam int STR_COUNT  = 4;   // number of LED strings
    localparam int WORD_W     = 8;   // width of the status word
    localparam int OV_POS     = 4;   // bit position of the overvoltage flag
    localparam logic [7:0] WORD_ADDR = 8'h0A;  // address of the status word

    typedef logic [WORD_W-1:0] fault_word_t;
endpackage

// File: rtl/fault_trip_sync.sv
// Module: fault_trip_sync
// Brings a vector of asynchronous comparator trips into the clock domain
// through two flops per bit.
// Assumes the trips are levels or pulses that last at least one clock.
module fault_trip_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] trip_async,
    output logic [W-1:0] trip_sync
);
    logic [W-1:0] stage1;

    // Two-flop synchroniser, cleared by the synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1    <= '0;
            trip_sync <= '0;
        end else begin
            stage1    <= trip_async;
            trip_sync <= stage1;
        end
    end
endmodule

// File: rtl/fault_sticky_bank.sv
// Module: fault_sticky_bank
// Holds one sticky flag per input. A flag is set on the first synchronised
// high and cleared only by reset or by a low global enable.
// Assumes the set inputs are already synchronous to clk.
module fault_sticky_bank #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic [W-1:0] set_in,
    output logic [W-1:0] flags
);
    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_flag
            // One sticky flag: clear has priority, then set, else hold.
            always_ff @(posedge clk) begin
                if (!rst_n || !enable) begin
                    flags[i] <= 1'b0;
                end else if (set_in[i]) begin
                    flags[i] <= 1'b1;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/led_short_fault_reg.sv
// Module: led_short_fault_reg (top)
// Latches string-short and overvoltage trips into the fault status word.
// Turns off shorted strings and tells the measurement controller which
// channels to freeze.
// Assumes drv_en and rst_n are synchronous to clk. The trip inputs may be
// asynchronous.
module led_short_fault_reg
    import led_fault_pkg::*;
#(
    parameter int NUM_STRINGS = STR_COUNT
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   drv_en,
    input  logic [NUM_STRINGS-1:0] short_trip,
    input  logic                   ov_trip,
    output logic [WORD_W-1:0]      fault_word,
    output logic [NUM_STRINGS-1:0] str_en,
    output logic [NUM_STRINGS-1:0] meas_freeze
);
    localparam int TRIP_W = NUM_STRINGS + 1;
    localparam int PAD_W  = WORD_W - TRIP_W;

    logic [TRIP_W-1:0] trips_raw;
    logic [TRIP_W-1:0] trips_sync;
    logic [TRIP_W-1:0] latched;

    // Gather the string trips and the overvoltage trip into one vector.
    always_comb trips_raw = {ov_trip, short_trip};

    fault_trip_sync #(.W(TRIP_W)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .trip_async(trips_raw),
        .trip_sync (trips_sync)
    );

    fault_sticky_bank #(.W(TRIP_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .enable(drv_en),
        .set_in(trips_sync),
        .flags (latched)
    );

    // Build the status word: the latched flags with the unused upper bits at zero.
    generate
        if (PAD_W > 0) begin : g_pad
            always_comb fault_word = {{PAD_W{1'b0}}, latched};
        end else begin : g_nopad
            always_comb fault_word = latched[WORD_W-1:0];
        end
    endgenerate

    genvar s;
    generate
        for (s = 0; s < NUM_STRINGS; s++) begin : g_str
            // Per-string enable and measurement freeze.
            always_comb begin
                str_en[s]      = drv_en & ~latched[s];
                meas_freeze[s] = latched[s];
            end
        end
    endgenerate
endmodule

// File: rtl/led_short_fault_chk.sv
// Module: led_short_fault_chk
// Property checker attached to led_short_fault_reg through bind.
module led_short_fault_chk #(
    parameter int N = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         drv_en,
    input logic [7:0]   fault_word,
    input logic [N-1:0] str_en,
    input logic [N-1:0] meas_freeze
);
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        fault_word[7:N+1] == '0);  // R6

    AST_SHORT_STICKY: assert property (@(posedge clk)
        (rst_n && drv_en) |=>
        ((fault_word[N-1:0] & $past(fault_word[N-1:0])) == $past(fault_word[N-1:0])));  // R3

    AST_DISABLE_CLEARS: assert property (@(posedge clk)
        (rst_n && !drv_en) |=> (fault_word[N:0] == '0));  // R7

    AST_ENABLE_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        str_en == (drv_en ? ~fault_word[N-1:0] : '0));  // R4

    AST_FREEZE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        meas_freeze == fault_word[N-1:0]);  // R8

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (fault_word == 8'h00));  // R1
endmodule

bind led_short_fault_reg led_short_fault_chk #(.N(NUM_STRINGS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .drv_en     (drv_en),
    .fault_word (fault_word),
    .str_en     (str_en),
    .meas_freeze(meas_freeze)
);

// File: tb/led_short_fault_reg_tb.sv
// Bench for led_short_fault_reg. A behavioural reference model is compared
// with the design at every falling edge.
module led_short_fault_reg_tb;
    localparam time PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       drv_en = 1'b0;
    logic [3:0] short_trip = '0;
    logic       ov_trip = 1'b0;
    logic [7:0] fault_word;
    logic [3:0] str_en;
    logic [3:0] meas_freeze;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    led_short_fault_reg u_dut (
        .clk(clk), .rst_n(rst_n), .drv_en(drv_en), .short_trip(short_trip),
        .ov_trip(ov_trip), .fault_word(fault_word), .str_en(str_en),
        .meas_freeze(meas_freeze)
    );

    always #(PERIOD/2) clk = ~clk;

    // Reference model: a queue of earlier trip samples and a sticky word.
    int hist[$];
    int model_word = 0;

    initial begin
        hist.push_back(0);
        hist.push_back(0);
    end

    always @(posedge clk) begin
        int oldest;
        if (!rst_n) begin
            hist.delete();
            hist.push_back(0);
            hist.push_back(0);
            model_word = 0;
        end else begin
            oldest = hist.pop_front();
            if (!drv_en) model_word = 0;
            else         model_word = model_word | oldest;
            hist.push_back({27'd0, ov_trip, short_trip});
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare against the model on every cycle once reset has been applied.
    bit compare_on = 0;
    always @(negedge clk) begin
        if (compare_on) begin
            chk("R2/R3 shorts",  int'(fault_word[3:0]), model_word & 15);
            chk("R5 overvoltage", int'(fault_word[4]), (model_word >> 4) & 1);
            chk("R6 reserved",   int'(fault_word[7:5]), 0);
            chk("R4 enables",    int'(str_en), drv_en ? (~model_word & 15) : 0);
            chk("R8 freeze",     int'(meas_freeze), model_word & 15);
        end
    end

    // Wait for n rising edges, then a quarter period, before driving.
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #(PERIOD/4);
    endtask

    initial begin
        step(3);
        compare_on = 1;
        rst_n  = 1'b1;
        drv_en = 1'b1;
        step(1);
        chk("R1 reset word", int'(fault_word), 0);
        chk("R1 reset enables", int'(str_en), 4'hF);

        // R9: a one-cycle pulse on string 1 latches; R10: the others are untouched.
        short_trip = 4'b0010;
        step(1);
        short_trip = 4'b0000;
        step(4);
        chk("R9 single pulse", int'(fault_word), 8'h02);
        chk("R10 other strings", int'(str_en), 4'b1101);

        // R2 latency: trip at edge N, visible after edge N+2.
        short_trip = 4'b1000;
        step(2);
        chk("R2 not yet", int'(fault_word[3]), 0);
        step(1);
        chk("R2 latched", int'(fault_word[3]), 1);
        short_trip = 4'b0000;
        step(3);
        chk("R3 sticky", int'(fault_word[3:0]), 4'b1010);

        // R5: overvoltage pulse.
        ov_trip = 1'b1;
        step(1);
        ov_trip = 1'b0;
        step(4);
        chk("R5 ov latched", int'(fault_word), 8'h1A);

        // R7: a low enable clears and blocks new trips.
        drv_en = 1'b0;
        short_trip = 4'b0101;
        step(1);
        chk("R7 cleared", int'(fault_word), 0);
        chk("R7 strings off", int'(str_en), 0);
        step(3);
        chk("R7 ignored", int'(fault_word), 0);
        short_trip = 4'b0000;
        step(3);
        drv_en = 1'b1;
        step(4);
        chk("R7 restart clean", int'(fault_word), 0);

        // Mixed patterns with enable toggling and resets.
        for (int k = 0; k < 400; k++) begin
            short_trip = (($urandom % 8) == 0) ? 4'($urandom) : 4'b0000;
            ov_trip    = (($urandom % 16) == 0);
            if (($urandom % 40) == 0) drv_en = ~drv_en;
            if (($urandom % 97) == 0) rst_n = 1'b0;
            else                      rst_n = 1'b1;
            step(1);
        end
        rst_n = 1'b1;
        step(2);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(PERIOD * 20000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule